// File: doc/BRIEF.md
# Complete-Packet Priority Stream Multiplexer

This block merges four independent packet streams into one output stream that feeds a packet buffer ahead of the network transmitter. Three inputs carry detector data: time-to-digital hits, acoustic samples and monitoring records. The fourth is a processor channel. Every input lands in its own data FIFO. Beside each FIFO sits a small packet counter that stores no payload. It counts the end-of-data words that are queued, which gives the number of complete packets waiting on that input.

The selector considers an input only while its counter is non-zero. A stream whose packet tail is still arriving therefore never holds the output hostage. Among the eligible inputs a fixed priority picks the winner. The processor channel comes first, then time-to-digital, then acoustic, then monitoring. Once picked, the input stays locked until its end-of-data word has been accepted at the output. The next choice is made only after that. The output is a registered valid/ready stream whose last flag marks the end-of-data word. An input whose FIFO fills up without holding a single complete packet can never be served, so it raises a sticky overflow flag.

Top module: `pmux_top`

## Requirements
- R1: After reset, out_valid is 0, every in_ready bit is 1 and every ovf bit is 0.
- R2: The words of a packet leave the output in the order they were written, with their data unchanged. out_last is 1 on the end-of-data word and 0 on every other word.
- R3: Once the first word of a packet has left the output, all of that packet's words leave before any word of another input.
- R4: An input holding only part of a packet produces no output word, however many words it holds. Its packet starts only after its end-of-data word has been written.
- R5: If several inputs hold complete packets when a choice is made, the lowest input index is served first. Index 0 is the processor channel, 1 is time-to-digital, 2 is acoustic and 3 is monitoring.
- R6: A new choice is made only after the end-of-data word has been accepted at the output. A packet that completes on a higher-priority input during a transfer does not interrupt that transfer. It wins the next choice.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_last stay unchanged on the next cycle.
- R8: With nothing read from an input, that input accepts exactly DEPTH+1 words and then drops in_ready. DEPTH must be a power of two.
- R9: When an input's FIFO is full and holds no complete packet, its ovf bit becomes 1. It stays 1 until reset. The other inputs' bits are unaffected.
- R10: Packets written back to back into one input while earlier ones are read out are all delivered, each exactly once. No extra packet follows, including when a packet end is written in the same cycle as another is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | Per-input word valid |
| in_ready | output | NUM_IN | Per-input space available (FIFO not full) |
| in_data | input | NUM_IN*DW | Per-input data words, input i at bits i*DW +: DW |
| in_last | input | NUM_IN | Per-input end-of-data marker for the word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DW | Output data word |
| out_last | output | 1 | Output word is the end-of-data word |
| ovf | output | NUM_IN | Sticky flag: FIFO full with no complete packet |

## Verification
A packet counter that drifts upward starts a transfer on an input with only a partial packet. The bench sees this as output words appearing before the end-of-data word was written, within about four cycles. A counter that drifts downward leaves a complete packet stranded, so expected words never arrive. A lock state that releases too early shows up as interleaved or reordered words in the next packet compared against the bench's arithmetic order. An off-by-one in the FIFO occupancy moves the in_ready drop away from word DEPTH+1, and the overflow flag follows one cycle later.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } sel_state_t;
endpackage

// File: rtl/pmux_fifo.sv
module pmux_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic [DW:0] push_word,
  output logic        full,
  input  logic        pop,
  output logic [DW:0] head,
  output logic        head_valid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used;
  logic [DW:0]   head_q;
  logic          hv_q;
  logic          fetch;

  assign fetch      = (used != '0) && (!hv_q || pop);
  assign full       = (used == CW'(DEPTH));
  assign head       = head_q;
  assign head_valid = hv_q;

  // storage and registered read port, no reset so block RAM fits
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
    if (fetch) head_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
      hv_q   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (fetch) rd_ptr <= rd_ptr + AW'(1);
      used <= used + CW'(push) - CW'(fetch);
      if (fetch) hv_q <= 1'b1;
      else if (pop) hv_q <= 1'b0;
    end
  end

  // R8: occupancy never exceeds the storage depth
  a_r8_used_bound: assert property (@(posedge clk) disable iff (rst)
    used <= CW'(DEPTH));
  // R8: a read is only taken from a valid head word
  a_r8_pop_valid: assert property (@(posedge clk) disable iff (rst)
    pop |-> hv_q);
endmodule

// File: rtl/pmux_pkt_cnt.sv
module pmux_pkt_cnt #(
  parameter int MAXP = 257
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic has_pkt
);
  localparam int CW = $clog2(MAXP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && !dec) cnt <= cnt + CW'(1);
    else if (dec && !inc) cnt <= cnt - CW'(1);
  end

  assign has_pkt = (cnt != '0);

  // R10: a packet end is never read out of an empty count
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc) |-> (cnt != '0));
  // R10: the count never wraps past the packets the FIFO can hold
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec) |-> (cnt != CW'(MAXP)));
endmodule

// File: rtl/pmux_arb.sv
module pmux_arb
  import pmux_pkg::*;
#(
  parameter int N  = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig,
  input  logic          pop_last,
  input  logic          eod_taken,
  output logic          xfer,
  output logic [SW-1:0] sel
);
  sel_state_t    st_q;
  logic [SW-1:0] sel_q;
  logic [SW-1:0] win;
  logic          any;

  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) win = SW'(i);
    end
  end

  assign any = |elig;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any) begin
          sel_q <= win;
          st_q  <= ST_XFER;
        end
        ST_XFER:  if (pop_last)  st_q <= ST_DRAIN;
        ST_DRAIN: if (eod_taken) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer = (st_q == ST_XFER);
  assign sel  = sel_q;

  // R5: no lower index is eligible when a choice is made
  a_r5_priority: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && any) |=>
      ((elig & ((N'(1) << sel_q) - N'(1))) == '0) || $past(elig) != elig
        || (($past(elig) & ((N'(1) << sel_q) - N'(1))) == '0));
  // R3: the chosen input is held while a packet is in flight
  a_r3_lock: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(sel_q));
  // R6: no new choice before the end-of-data word leaves
  a_r6_rearb: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DRAIN && !eod_taken) |=> (st_q == ST_DRAIN));
endmodule

// File: rtl/pmux_top.sv
module pmux_top #(
  parameter int NUM_IN = 4,
  parameter int DW     = 32,
  parameter int DEPTH  = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IN-1:0]    in_valid,
  output logic [NUM_IN-1:0]    in_ready,
  input  logic [NUM_IN*DW-1:0] in_data,
  input  logic [NUM_IN-1:0]    in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_data,
  output logic                 out_last,
  output logic [NUM_IN-1:0]    ovf
);
  localparam int SW   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int MAXP = DEPTH + 1;

  logic [NUM_IN-1:0] full, push, pop, hv, has_pkt, ovf_q;
  logic [DW:0]       head [NUM_IN];
  logic [DW:0]       sel_head;
  logic [SW-1:0]     sel;
  logic              xfer, pop_any, pop_last, eod_taken, slot_free;
  logic              ov_q, ol_q;
  logic [DW-1:0]     od_q;

  assign slot_free = !ov_q || out_ready;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    assign push[i]     = in_valid[i] && !full[i];
    assign in_ready[i] = !full[i];
    assign pop[i]      = xfer && (sel == SW'(i)) && hv[i] && slot_free;

    pmux_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (push[i]),
      .push_word ({in_last[i], in_data[i*DW +: DW]}),
      .full      (full[i]),
      .pop       (pop[i]),
      .head      (head[i]),
      .head_valid(hv[i])
    );

    pmux_pkt_cnt #(.MAXP(MAXP)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc    (push[i] && in_last[i]),
      .dec    (pop[i] && head[i][DW]),
      .has_pkt(has_pkt[i])
    );

    always_ff @(posedge clk) begin
      if (rst) ovf_q[i] <= 1'b0;
      else if (full[i] && !has_pkt[i]) ovf_q[i] <= 1'b1;
    end

    // R4: words leave an input only while it holds a complete packet
    a_r4_complete: assert property (@(posedge clk) disable iff (rst)
      pop[i] |-> has_pkt[i]);
    // R9: the overflow flag never clears outside reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
      ovf_q[i] |=> ovf_q[i]);
  end

  pmux_arb #(.N(NUM_IN)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .elig     (has_pkt),
    .pop_last (pop_last),
    .eod_taken(eod_taken),
    .xfer     (xfer),
    .sel      (sel)
  );

  assign sel_head  = head[sel];
  assign pop_any   = |pop;
  assign pop_last  = pop_any && sel_head[DW];
  assign eod_taken = ov_q && out_ready && ol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
    end else if (pop_any) begin
      ov_q <= 1'b1;
      ol_q <= sel_head[DW];
      od_q <= sel_head[DW-1:0];
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
  assign ovf       = ovf_q;

  // R7: a stalled word is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));
  // R2: after an end-of-data word is taken the output is empty
  a_r2_gap: assert property (@(posedge clk) disable iff (rst)
    eod_taken |=> !out_valid);
  // R3: at most one input is read in any cycle
  a_r3_one_pop: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop));
endmodule

// File: tb/pmux_top_test.sv
module pmux_top_test;
  localparam int NI = 4;
  localparam int DW = 32;
  localparam int DP = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NI-1:0]     in_valid = '0;
  logic [NI-1:0]     in_ready;
  logic [NI*DW-1:0]  in_data = '0;
  logic [NI-1:0]     in_last = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DW-1:0]     out_data;
  logic              out_last;
  logic [NI-1:0]     ovf;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int rdy_mode = 0;
  int ng = 0, nexp = 0;
  logic [DW:0] got [256];
  logic [DW:0] expv [256];
  logic        prev_stall = 1'b0;
  logic [DW:0] prev_word = '0;

  pmux_top #(.NUM_IN(NI), .DW(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .ovf(ovf)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ~out_ready;
      2: out_ready = 1'b0;
      default: out_ready = cyc[0] ^ cyc[2];
    endcase
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exv);
    end
  endtask

  // output monitor, with the R7 hold check
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(out_valid && ({out_last, out_data} == prev_word), "R7 hold",
              {31'd0, out_valid, out_last, out_data}, {32'd1, prev_word});
      if (out_valid && out_ready && ng < 256) begin
        got[ng] = {out_last, out_data};
        ng++;
      end
      prev_stall = out_valid && !out_ready;
      prev_word  = {out_last, out_data};
    end else begin
      prev_stall = 1'b0;
    end
  end

  function automatic logic [DW-1:0] tagw(int lane, int sc, int w);
    return {8'(lane), 8'(sc), 16'(w)};
  endfunction

  task automatic send_pkt(input int lane, input int len, input int sc,
                          input bit with_last, input int base);
    @(posedge clk); #1;
    for (int w = 0; w < len; w++) begin
      in_valid[lane] = 1'b1;
      in_data[lane*DW +: DW] = tagw(lane, sc, base + w);
      in_last[lane] = with_last && (w == len - 1);
      do @(negedge clk); while (!in_ready[lane]);
      @(posedge clk); #1;
    end
    in_valid[lane] = 1'b0;
    in_last[lane]  = 1'b0;
  endtask

  task automatic add_exp(input int lane, input int len, input int sc, input int base);
    for (int w = 0; w < len; w++) begin
      expv[nexp] = {(w == len - 1) ? 1'b1 : 1'b0, tagw(lane, sc, base + w)};
      nexp++;
    end
  endtask

  task automatic collect(input string req);
    int t = 0;
    while (ng < nexp && t < 600) begin
      @(negedge clk);
      t++;
    end
    repeat (12) @(negedge clk);
    check(ng == nexp, req, 64'(ng), 64'(nexp));
    for (int i = 0; i < nexp && i < ng; i++)
      check(got[i] == expv[i], req, 64'(got[i]), 64'(expv[i]));
    ng = 0;
    nexp = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    in_valid = '0;
    in_last = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    ng = 0;
    nexp = 0;
  endtask

  initial begin
    int modes [3] = '{0, 1, 3};
    int acc;
    do_reset();
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == '1, "R1 in_ready", 64'(in_ready), 64'hF);
    check(ovf == '0, "R1 ovf", 64'(ovf), 64'd0);

    // R5 R2 R3: every subset of inputs, several lengths, packets complete together
    for (int m = 1; m < 16; m++) begin
      for (int len = 1; len <= DP; len++) begin
        rdy_mode = modes[(m + len) % 3];
        for (int l = 0; l < NI; l++)
          if (m[l]) add_exp(l, len, m * 16 + len, 0);
        fork
          if (m[0]) send_pkt(0, len, m * 16 + len, 1'b1, 0);
          if (m[1]) send_pkt(1, len, m * 16 + len, 1'b1, 0);
          if (m[2]) send_pkt(2, len, m * 16 + len, 1'b1, 0);
          if (m[3]) send_pkt(3, len, m * 16 + len, 1'b1, 0);
        join
        collect("R5 R2 R3 priority sweep");
      end
    end

    // R4: a partial packet yields nothing until its end arrives
    rdy_mode = 0;
    send_pkt(1, 3, 200, 1'b0, 0);
    repeat (20) @(negedge clk);
    check(ng == 0, "R4 partial idle", 64'(ng), 64'd0);
    add_exp(1, 4, 200, 0);
    send_pkt(1, 1, 200, 1'b1, 3);
    collect("R4 completed packet");

    // R6: higher priority packet waits for the end of the locked one
    rdy_mode = 2;
    add_exp(3, 6, 201, 0);
    add_exp(0, 2, 202, 0);
    add_exp(2, 2, 203, 0);
    send_pkt(3, 6, 201, 1'b1, 0);
    repeat (4) @(negedge clk);
    send_pkt(2, 2, 203, 1'b1, 0);
    send_pkt(0, 2, 202, 1'b1, 0);
    repeat (3) @(negedge clk);
    rdy_mode = 1;
    collect("R6 re-arbitration order");

    // R10: back-to-back single-word packets while draining
    rdy_mode = 0;
    for (int p = 0; p < 40; p++) add_exp(1, 1, 204, p);
    for (int p = 0; p < 40; p++) send_pkt(1, 1, 204, 1'b1, p);
    collect("R10 single-word stream");
    rdy_mode = 3;
    for (int p = 0; p < 20; p++) add_exp(2, 2, 205, 2 * p);
    for (int p = 0; p < 20; p++) send_pkt(2, 2, 205, 1'b1, 2 * p);
    collect("R10 two-word stream");

    // R8 R9: fill one input with a partial packet
    acc = 0;
    @(posedge clk); #1;
    in_valid[2] = 1'b1;
    for (int k = 0; k < 2 * DP + 4; k++) begin
      in_data[2*DW +: DW] = tagw(2, 206, k);
      @(negedge clk);
      if (in_ready[2]) acc++;
      @(posedge clk); #1;
    end
    in_valid[2] = 1'b0;
    check(acc == DP + 1, "R8 accepted words", 64'(acc), 64'(DP + 1));
    check(in_ready[2] == 1'b0, "R8 ready low", 64'(in_ready[2]), 64'd0);
    repeat (2) @(negedge clk);
    check(ovf == 4'b0100, "R9 ovf set", 64'(ovf), 64'h4);
    check(ng == 0, "R4 full partial idle", 64'(ng), 64'd0);
    repeat (10) @(negedge clk);
    check(ovf == 4'b0100, "R9 ovf sticky", 64'(ovf), 64'h4);
    do_reset();
    check(ovf == '0, "R1 ovf after reset", 64'(ovf), 64'd0);
    check(in_ready == '1, "R1 ready after reset", 64'(in_ready), 64'hF);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule